// File: doc/BRIEF.md
# Three-Wire Serial Register Access Interface

This block is the slave side of a three-wire synchronous link. The link has an enable line, a serial clock and one bidirectional data line. While the enable line is high, a host shifts in a command byte and then either shifts data bytes in or clocks data bytes out. Every byte travels least-significant bit first. Incoming bits are taken on rising serial-clock edges and outgoing bits change on falling edges. The command byte picks a space: the timekeeping register bank or a scratch RAM of `RAM_DEPTH` bytes. It also picks an address, a direction, and a single-byte or burst transfer. The block itself holds the write-protect control register, which sits at the top of the clock space.

The three link inputs are synchronised into the system clock domain, and the block detects serial-clock edges there. A state machine steps through five states:

- `ST_IDLE`: the link is closed.
- `ST_CMD`: command bits are being collected.
- `ST_WR`: data is being received.
- `ST_RD`: data is being sent.
- `ST_DONE`: the remaining clocks are ignored.

The transitions are:

- *link-off*: any state goes to `ST_IDLE` when the enable line drops.
- *open*: `ST_IDLE` goes to `ST_CMD` while the enable line is high.
- *reject*: `ST_CMD` goes to `ST_DONE` when the top command bit is 0.
- *write-go*: `ST_CMD` goes to `ST_WR`.
- *read-go*: `ST_CMD` goes to `ST_RD`.
- *write-end*: `ST_WR` goes to `ST_DONE` after the last byte the mode accepts.

`ST_RD` leaves only by *link-off*.

Writes to the clock bank come out as a one-cycle strobe with a lane mask. RAM writes come out as a one-cycle strobe with an address. RAM read data is expected combinationally from `ram_raddr_o`.

Top module: `serial_reg_port`

## Requirements
- R1: Raising the enable line opens a transfer. Lowering it at any point abandons the transfer, and the data output enable is low within a few system cycles. The data output enable is low after reset.
- R2: The command byte is decoded as follows. Bit 7 must be 1, or the whole transfer causes no write and drives no data. Bit 6 selects the clock bank when 0 and the RAM when 1. Bits 5:1 are the address. Bit 0 means read when 1 and write when 0.
- R3: Command and data bits are least-significant first and are captured on rising serial-clock edges. On a read, the data output is enabled and bit 0 is driven on the first falling edge after the eighth command bit, and not before.
- R4: In a single-byte write, exactly one byte is stored. Any further serial clocks before the enable line drops store nothing.
- R5: While the enable line stays high, a single-byte read keeps resending the same byte. A burst read restarts at address 0 after the last location of its space.
- R6: Address 31 selects burst mode, starting at address 0. A clock burst covers 8 registers, where address 7 is the control register. A RAM burst covers `RAM_DEPTH` bytes.
- R7: The control register is clock address 7. Its bit 7 is write protect, and bits 6:0 always read as 0. It resets to 0.
- R8: While write protect is 1, no write reaches the RAM or clock registers 0–6. The control register itself stays writable.
- R9: A clock burst write issues one strobe with all lanes set, and only after all eight bytes have arrived. A shorter burst changes nothing. A single clock write sets exactly one lane, at bit position equal to the address.
- R10: In a RAM burst write, each byte is stored as soon as its eighth bit arrives, so a burst cut short keeps the bytes already completed.
- R11: Clock addresses 8–30 and RAM addresses from `RAM_DEPTH` to 30 hold nothing. Reads from them return 0 and writes to them cause no strobe.
- R12: A clock read copies all clock registers when its command completes. Later changes to the clock registers do not alter the bytes sent in that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_en_i | input | 1 | Link enable line (asynchronous) |
| ser_clk_i | input | 1 | Serial clock (asynchronous) |
| ser_data_i | input | 1 | Serial data from the host |
| ser_data_o | output | 1 | Serial data to the host |
| ser_data_oe_o | output | 1 | Output enable for the data pad |
| tk_rdata_i | input | 8*(CLK_REGS-1) | Current clock registers, register i in bits 8i+7:8i |
| tk_we_o | output | 1 | Clock register write strobe |
| tk_wsel_o | output | CLK_REGS-1 | Lane mask for the strobe |
| tk_wdata_o | output | 8*(CLK_REGS-1) | Write data, lane i in bits 8i+7:8i |
| ram_raddr_o | output | 5 | RAM read address |
| ram_rdata_i | input | 8 | RAM read data for ram_raddr_o |
| ram_we_o | output | 1 | RAM write strobe |
| ram_waddr_o | output | 5 | RAM write address |
| ram_wdata_o | output | 8 | RAM write data |

## Verification
Single-byte writes and reads at random RAM addresses with random data show whether bit order and address decoding are right. A wrong bit order or a swapped field shows up as a mismatch on read-back. Directed patterns separate the modes that behave alike on the ports:

- a single write followed by extra bytes, against a burst write;
- a burst cut short in the clock space, against one cut short in the RAM space;
- repeated reads of one address, against a burst read that wraps.

Write protect, empty addresses, a rejected command byte, an abort in the middle of a read, and a clock change in the middle of a burst read are each followed by a read-back. That read-back shows whether the stimulus left any trace.

// File: rtl/srp_pkg.sv
package srp_pkg;

    localparam int CMD_W  = 8;
    localparam int ADDR_W = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WR,
        ST_RD,
        ST_DONE
    } srp_state_e;

    function automatic logic addr_is_burst(input logic [ADDR_W-1:0] a);
        return &a;
    endfunction

endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o
);

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_line
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= '0;
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], async_i[g]};
                end
            end
            assign level_o[g] = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/srp_stage.sv
module srp_stage #(
    parameter int NREG = 7,
    localparam int IW  = $clog2(NREG + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [IW-1:0]   idx_i,
    input  logic [7:0]      byte_i,
    output logic [NREG*8-1:0] data_o
);

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_slot
            logic [7:0] slot_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    slot_q <= '0;
                end else if (we_i && idx_i == IW'(g)) begin
                    slot_q <= byte_i;
                end
            end
            assign data_o[g*8 +: 8] = slot_q;
        end
    endgenerate

endmodule

// File: rtl/srp_readmux.sv
module srp_readmux
    import srp_pkg::*;
#(
    parameter int NREG      = 7,
    parameter int RAM_DEPTH = 24,
    localparam int IW       = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snap_en_i,
    input  logic [NREG*8-1:0] tk_rdata_i,
    input  logic              wp_i,
    input  logic [7:0]        ram_rdata_i,
    input  logic              is_ram_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [7:0]        rbyte_o
);

    localparam logic [ADDR_W-1:0] RAM_LAST  = ADDR_W'(RAM_DEPTH - 1);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NREG);

    logic [7:0] snap_q [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) snap_q[i] <= '0;
        end else if (snap_en_i) begin
            for (int i = 0; i < NREG; i++) snap_q[i] <= tk_rdata_i[i*8 +: 8];
        end
    end

    always_comb begin
        rbyte_o = '0;
        if (is_ram_i) begin
            if (addr_i <= RAM_LAST) rbyte_o = ram_rdata_i;
        end else if (addr_i == CTRL_ADDR) begin
            rbyte_o = {wp_i, 7'b0};
        end else if (addr_i < CTRL_ADDR) begin
            rbyte_o = snap_q[addr_i[IW-1:0]];
        end
    end

endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
    import srp_pkg::*;
#(
    parameter int RAM_DEPTH   = 24,
    parameter int CLK_REGS    = 8,
    parameter int SYNC_STAGES = 2,
    localparam int TK_REGS    = CLK_REGS - 1,
    localparam int TK_W       = TK_REGS * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_en_i,
    input  logic              ser_clk_i,
    input  logic              ser_data_i,
    output logic              ser_data_o,
    output logic              ser_data_oe_o,
    input  logic [TK_W-1:0]   tk_rdata_i,
    output logic              tk_we_o,
    output logic [TK_REGS-1:0] tk_wsel_o,
    output logic [TK_W-1:0]   tk_wdata_o,
    output logic [ADDR_W-1:0] ram_raddr_o,
    input  logic [7:0]        ram_rdata_i,
    output logic              ram_we_o,
    output logic [ADDR_W-1:0] ram_waddr_o,
    output logic [7:0]        ram_wdata_o
);

    localparam int IW = $clog2(CLK_REGS);
    localparam logic [ADDR_W-1:0] RAM_LAST  = ADDR_W'(RAM_DEPTH - 1);
    localparam logic [ADDR_W-1:0] CLK_LAST  = ADDR_W'(CLK_REGS - 1);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = CLK_LAST;

    // ---------------- line synchronisers and clock edge detection
    logic [2:0] lines_lvl;
    logic       en_lvl, sclk_lvl, din_lvl;
    logic       sclk_prev_q, sclk_rise, sclk_fall;

    srp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_data_i, ser_clk_i, ser_en_i}),
        .level_o (lines_lvl)
    );

    assign en_lvl   = lines_lvl[0];
    assign sclk_lvl = lines_lvl[1];
    assign din_lvl  = lines_lvl[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev_q <= 1'b0;
        else        sclk_prev_q <= sclk_lvl;
    end

    assign sclk_rise = sclk_lvl & ~sclk_prev_q;
    assign sclk_fall = ~sclk_lvl & sclk_prev_q;

    // ---------------- state and datapath registers
    srp_state_e        state_q, state_d;
    logic [2:0]        bit_q;
    logic [6:0]        cmd_q;
    logic [6:0]        rx_q;
    logic [6:0]        tx_q;
    logic [ADDR_W-1:0] addr_q;
    logic              is_ram_q, burst_q, wp_q;
    logic              dout_q, oe_q;
    logic              ram_we_q;
    logic [ADDR_W-1:0] ram_waddr_q;
    logic [7:0]        ram_wdata_q;
    logic              tk_we_q;
    logic [TK_REGS-1:0] tk_wsel_q;
    logic [TK_W-1:0]   tk_wdata_q;

    logic [7:0]        cmd_full, rx_full, rbyte;
    logic              burst_cmd, byte_in_done, wr_last;
    logic [ADDR_W-1:0] space_last, rd_next;
    logic              snap_en, stage_we;
    logic [TK_W-1:0]   stage_data;

    assign cmd_full     = {din_lvl, cmd_q};
    assign rx_full      = {din_lvl, rx_q};
    assign burst_cmd    = addr_is_burst(cmd_full[5:1]);
    assign byte_in_done = sclk_rise && (bit_q == 3'd7);
    assign space_last   = is_ram_q ? RAM_LAST : CLK_LAST;
    assign wr_last      = !burst_q || (addr_q == space_last);
    assign rd_next      = !burst_q ? addr_q :
                          (addr_q == space_last) ? '0 : addr_q + ADDR_W'(1);

    assign snap_en  = (state_q == ST_CMD) && en_lvl && byte_in_done &&
                      cmd_full[7] && !cmd_full[6] && cmd_full[0];
    assign stage_we = (state_q == ST_WR) && en_lvl && byte_in_done &&
                      !is_ram_q && burst_q && (addr_q < CTRL_ADDR);

    // ---------------- submodules
    srp_stage #(.NREG(TK_REGS)) u_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (stage_we),
        .idx_i  (addr_q[IW-1:0]),
        .byte_i (rx_full),
        .data_o (stage_data)
    );

    srp_readmux #(.NREG(TK_REGS), .RAM_DEPTH(RAM_DEPTH)) u_rmux (
        .clk         (clk),
        .rst_n       (rst_n),
        .snap_en_i   (snap_en),
        .tk_rdata_i  (tk_rdata_i),
        .wp_i        (wp_q),
        .ram_rdata_i (ram_rdata_i),
        .is_ram_i    (is_ram_q),
        .addr_i      (addr_q),
        .rbyte_o     (rbyte)
    );

    // ---------------- next state
    always_comb begin
        state_d = state_q;
        if (!en_lvl) begin
            state_d = ST_IDLE;                       // link-off
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_CMD;           // open
                ST_CMD: begin
                    if (byte_in_done) begin
                        if (!cmd_full[7])     state_d = ST_DONE; // reject
                        else if (cmd_full[0]) state_d = ST_RD;   // read-go
                        else                  state_d = ST_WR;   // write-go
                    end
                end
                ST_WR: begin
                    if (byte_in_done && wr_last) state_d = ST_DONE; // write-end
                end
                ST_RD:   state_d = ST_RD;
                ST_DONE: state_d = ST_DONE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // ---------------- state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q       <= '0;
            cmd_q       <= '0;
            rx_q        <= '0;
            tx_q        <= '0;
            addr_q      <= '0;
            is_ram_q    <= 1'b0;
            burst_q     <= 1'b0;
            wp_q        <= 1'b0;
            dout_q      <= 1'b0;
            oe_q        <= 1'b0;
            ram_we_q    <= 1'b0;
            ram_waddr_q <= '0;
            ram_wdata_q <= '0;
            tk_we_q     <= 1'b0;
            tk_wsel_q   <= '0;
            tk_wdata_q  <= '0;
        end else begin
            ram_we_q <= 1'b0;
            tk_we_q  <= 1'b0;
            if (!en_lvl || state_q == ST_IDLE) begin
                bit_q <= '0;
                oe_q  <= 1'b0;
            end else begin
                case (state_q)
                    ST_CMD: begin
                        if (sclk_rise) begin
                            cmd_q <= cmd_full[7:1];
                            bit_q <= bit_q + 3'd1;
                            if (bit_q == 3'd7) begin
                                is_ram_q <= cmd_full[6];
                                burst_q  <= burst_cmd;
                                addr_q   <= burst_cmd ? '0 : cmd_full[5:1];
                            end
                        end
                    end
                    ST_WR: begin
                        if (sclk_rise) begin
                            rx_q  <= rx_full[7:1];
                            bit_q <= bit_q + 3'd1;
                            if (bit_q == 3'd7) begin
                                if (burst_q) addr_q <= addr_q + ADDR_W'(1);
                                if (is_ram_q) begin
                                    if (addr_q <= RAM_LAST && !wp_q) begin
                                        ram_we_q    <= 1'b1;
                                        ram_waddr_q <= addr_q;
                                        ram_wdata_q <= rx_full;
                                    end
                                end else if (addr_q == CTRL_ADDR) begin
                                    wp_q <= rx_full[7];
                                    if (burst_q && !wp_q) begin
                                        tk_we_q    <= 1'b1;
                                        tk_wsel_q  <= '1;
                                        tk_wdata_q <= stage_data;
                                    end
                                end else if (addr_q < CTRL_ADDR && !burst_q && !wp_q) begin
                                    tk_we_q    <= 1'b1;
                                    tk_wsel_q  <= TK_REGS'(1) << addr_q[IW-1:0];
                                    tk_wdata_q <= {TK_REGS{rx_full}};
                                end
                            end
                        end
                    end
                    ST_RD: begin
                        if (sclk_fall) begin
                            oe_q  <= 1'b1;
                            bit_q <= bit_q + 3'd1;
                            if (bit_q == 3'd0) begin
                                dout_q <= rbyte[0];
                                tx_q   <= rbyte[7:1];
                            end else begin
                                dout_q <= tx_q[0];
                                tx_q   <= {1'b0, tx_q[6:1]};
                                if (bit_q == 3'd7) addr_q <= rd_next;
                            end
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    assign ser_data_o    = dout_q;
    assign ser_data_oe_o = oe_q;
    assign tk_we_o       = tk_we_q;
    assign tk_wsel_o     = tk_wsel_q;
    assign tk_wdata_o    = tk_wdata_q;
    assign ram_raddr_o   = addr_q;
    assign ram_we_o      = ram_we_q;
    assign ram_waddr_o   = ram_waddr_q;
    assign ram_wdata_o   = ram_wdata_q;

endmodule

// File: rtl/serial_reg_port_chk.sv
module serial_reg_port_chk
    import srp_pkg::*;
#(
    parameter int RAM_DEPTH = 24,
    parameter int TK_REGS   = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en_lvl,
    input logic               sclk_fall,
    input srp_state_e         state_q,
    input logic               wp_q,
    input logic               ser_data_o,
    input logic               ser_data_oe_o,
    input logic               tk_we_o,
    input logic [TK_REGS-1:0] tk_wsel_o,
    input logic               ram_we_o,
    input logic [ADDR_W-1:0]  ram_waddr_o
);

    localparam logic [ADDR_W-1:0] RAM_LAST = ADDR_W'(RAM_DEPTH - 1);

    assert_link_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_lvl |=> !ser_data_oe_o);

    assert_drive_only_reading_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ser_data_oe_o |-> (state_q == ST_RD));

    assert_dout_moves_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_fall |=> $stable(ser_data_o));

    assert_protect_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tk_we_o || ram_we_o) |-> !wp_q);

    assert_lane_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tk_we_o |-> (($countones(tk_wsel_o) == 1) || (&tk_wsel_o)));

    assert_ram_in_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |-> (ram_waddr_o <= RAM_LAST));

endmodule

bind serial_reg_port serial_reg_port_chk #(
    .RAM_DEPTH (RAM_DEPTH),
    .TK_REGS   (TK_REGS)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_lvl        (en_lvl),
    .sclk_fall     (sclk_fall),
    .state_q       (state_q),
    .wp_q          (wp_q),
    .ser_data_o    (ser_data_o),
    .ser_data_oe_o (ser_data_oe_o),
    .tk_we_o       (tk_we_o),
    .tk_wsel_o     (tk_wsel_o),
    .ram_we_o      (ram_we_o),
    .ram_waddr_o   (ram_waddr_o)
);

// File: tb/serial_reg_port_tb_top.sv
module serial_reg_port_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int NRAM       = 24;
    localparam int NTK        = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, sclk = 1'b0, din = 1'b0;
    logic dout, oe;
    logic [NTK*8-1:0] tk_m = 56'h66554433221100;
    logic tk_we;
    logic [NTK-1:0] tk_wsel;
    logic [NTK*8-1:0] tk_wdata;
    logic [4:0] raddr, waddr;
    logic [7:0] rdata, wdata;
    logic ram_we;
    logic [7:0] ram_m [NRAM] = '{default: 8'h00};

    int checks = 0, failures = 0;
    int ram_we_cnt = 0, tk_we_cnt = 0;
    logic poke_go = 1'b0;
    int poke_idx = 0;
    logic [7:0] poke_val = '0;

    logic [7:0] exp_ram [NRAM];
    logic [7:0] exp_tk [NTK];
    logic exp_wp;
    logic [7:0] rbuf [32];
    logic pre_oe, oe_any, oe_all;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_reg_port dut_i (
        .clk(clk), .rst_n(rst_n),
        .ser_en_i(en), .ser_clk_i(sclk), .ser_data_i(din),
        .ser_data_o(dout), .ser_data_oe_o(oe),
        .tk_rdata_i(tk_m), .tk_we_o(tk_we), .tk_wsel_o(tk_wsel), .tk_wdata_o(tk_wdata),
        .ram_raddr_o(raddr), .ram_rdata_i(rdata),
        .ram_we_o(ram_we), .ram_waddr_o(waddr), .ram_wdata_o(wdata)
    );

    assign rdata = (raddr < 5'(NRAM)) ? ram_m[raddr] : 8'h00;

    always @(posedge clk) begin
        if (ram_we) begin
            ram_we_cnt <= ram_we_cnt + 1;
            if (waddr < 5'(NRAM)) ram_m[waddr] <= wdata;
        end
        if (tk_we) begin
            tk_we_cnt <= tk_we_cnt + 1;
            for (int i = 0; i < NTK; i++)
                if (tk_wsel[i]) tk_m[i*8 +: 8] <= tk_wdata[i*8 +: 8];
        end
        if (poke_go) tk_m[poke_idx*8 +: 8] <= poke_val;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mk_cmd(input logic ram, input logic [4:0] a, input logic rd);
        return {1'b1, ram, a, rd};
    endfunction

    function automatic logic [7:0] exp_read(input logic ram, input logic [4:0] a);
        if (ram) return (a < 5'(NRAM)) ? exp_ram[a] : 8'h00;
        if (a < 5'(NTK)) return exp_tk[a];
        if (a == 5'(NTK)) return {exp_wp, 7'b0};
        return 8'h00;
    endfunction

    task automatic hold();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic start();
        sclk = 1'b0; en = 1'b1; hold();
    endtask

    task automatic stop();
        sclk = 1'b0; hold(); en = 1'b0; hold(); hold();
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            sclk = 1'b0; din = b[i]; hold();
            sclk = 1'b1; hold();
        end
    endtask

    task automatic recv_byte(output logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            sclk = 1'b0; hold();
            b[i] = dout; oe_any |= oe; oe_all &= oe;
            sclk = 1'b1; hold();
        end
    endtask

    task automatic do_write(input logic [7:0] cmd, input logic [7:0] d);
        start(); send_byte(cmd); send_byte(d); stop();
    endtask

    task automatic do_read(input logic [7:0] cmd, input int n);
        start(); send_byte(cmd);
        pre_oe = oe; oe_any = 1'b0; oe_all = 1'b1;
        for (int k = 0; k < n; k++) recv_byte(rbuf[k]);
        stop();
    endtask

    task automatic check_tk(input string req);
        for (int i = 0; i < NTK; i++) chk(req, tk_m[i*8 +: 8], exp_tk[i]);
    endtask

    initial begin
        int c0;
        logic [7:0] v;
        logic [4:0] a;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NRAM; i++) exp_ram[i] = 8'h00;
        for (int i = 0; i < NTK; i++) exp_tk[i] = 8'(i * 8'h11);
        exp_wp = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset oe", oe, 1'b0);
        chk("R1 reset strobes", {tk_we, ram_we}, 2'b00);

        // R3 single RAM write / read, bit order and first-bit timing
        do_write(mk_cmd(1, 5'd5, 0), 8'hA6); exp_ram[5] = 8'hA6;
        chk("R3 ram store", ram_m[5], 8'hA6);
        chk("R3 one strobe", ram_we_cnt, 1);
        do_read(mk_cmd(1, 5'd5, 1), 1);
        chk("R3 no drive before first fall", pre_oe, 1'b0);
        chk("R3 read lsb first", rbuf[0], 8'hA6);
        chk("R3 oe during read", oe_all, 1'b1);

        // R4 extra clocks after single write
        c0 = ram_we_cnt;
        start(); send_byte(mk_cmd(1, 5'd6, 0)); send_byte(8'h3C);
        send_byte(8'hFF); send_byte(8'h5A); stop(); exp_ram[6] = 8'h3C;
        chk("R4 single strobe", ram_we_cnt - c0, 1);
        chk("R4 next cell untouched", ram_m[7], 8'h00);

        // R5 single read retransmits
        do_read(mk_cmd(1, 5'd6, 1), 3);
        chk("R5 repeat 0", rbuf[0], 8'h3C);
        chk("R5 repeat 2", rbuf[2], 8'h3C);

        // R2 rejected command (bit 7 = 0)
        c0 = ram_we_cnt;
        do_write(8'h4C, 8'h55);
        chk("R2 reject write", ram_we_cnt - c0, 0);
        do_read(8'h4D, 1);
        chk("R2 reject read no drive", oe_any, 1'b0);

        // R2/R9 single clock write selects clock space
        c0 = tk_we_cnt;
        do_write(mk_cmd(0, 5'd2, 0), 8'h45); exp_tk[2] = 8'h45;
        chk("R9 single clock strobe", tk_we_cnt - c0, 1);
        check_tk("R2 clock space write");
        chk("R2 ram untouched", ram_m[2], 8'h00);
        do_read(mk_cmd(0, 5'd2, 1), 1);
        chk("R2 clock read", rbuf[0], 8'h45);

        // R11 empty addresses
        c0 = ram_we_cnt;
        do_write(mk_cmd(1, 5'd27, 0), 8'h77);
        chk("R11 ram hole write", ram_we_cnt - c0, 0);
        do_read(mk_cmd(1, 5'd27, 1), 1);
        chk("R11 ram hole read", rbuf[0], 8'h00);
        c0 = tk_we_cnt;
        do_write(mk_cmd(0, 5'd12, 0), 8'h77);
        chk("R11 clock hole write", tk_we_cnt - c0, 0);
        do_read(mk_cmd(0, 5'd12, 1), 1);
        chk("R11 clock hole read", rbuf[0], 8'h00);

        // R7/R8 write protect
        do_write(mk_cmd(0, 5'd7, 0), 8'hFF); exp_wp = 1'b1;
        do_read(mk_cmd(0, 5'd7, 1), 1);
        chk("R7 control reads 80", rbuf[0], 8'h80);
        c0 = ram_we_cnt;
        do_write(mk_cmd(1, 5'd5, 0), 8'h00);
        chk("R8 ram blocked", ram_we_cnt - c0, 0);
        do_read(mk_cmd(1, 5'd5, 1), 1);
        chk("R8 ram kept", rbuf[0], 8'hA6);
        c0 = tk_we_cnt;
        do_write(mk_cmd(0, 5'd3, 0), 8'h12);
        chk("R8 clock blocked", tk_we_cnt - c0, 0);
        do_write(mk_cmd(0, 5'd7, 0), 8'h00); exp_wp = 1'b0;
        do_read(mk_cmd(0, 5'd7, 1), 1);
        chk("R7 control cleared", rbuf[0], 8'h00);

        // R9 clock burst: partial does nothing, full commits once
        c0 = tk_we_cnt;
        start(); send_byte(mk_cmd(0, 5'd31, 0));
        for (int i = 0; i < 4; i++) send_byte(8'hE0 + 8'(i));
        stop();
        chk("R9 partial burst no strobe", tk_we_cnt - c0, 0);
        check_tk("R9 partial burst unchanged");
        start(); send_byte(mk_cmd(0, 5'd31, 0));
        for (int i = 0; i < NTK; i++) begin
            v = 8'h20 + 8'(i * 3); send_byte(v); exp_tk[i] = v;
        end
        send_byte(8'h00); stop();
        chk("R9 full burst one strobe", tk_we_cnt - c0, 1);
        check_tk("R9 full burst values");
        do_read(mk_cmd(0, 5'd31, 1), 8);
        for (int i = 0; i < 8; i++) chk("R6 clock burst read", rbuf[i], exp_read(0, 5'(i)));

        // R10 partial RAM burst keeps completed bytes
        c0 = ram_we_cnt;
        start(); send_byte(mk_cmd(1, 5'd31, 0));
        for (int i = 0; i < 5; i++) begin
            v = 8'h90 + 8'(i); send_byte(v); exp_ram[i] = v;
        end
        send_byte(8'hF0); send_byte(8'h0F);
        sclk = 1'b0; din = 1'b1; hold(); sclk = 1'b1; hold();
        stop(); exp_ram[5] = 8'hF0; exp_ram[6] = 8'h0F;
        chk("R10 per-byte strobes", ram_we_cnt - c0, 7);
        chk("R10 byte 4 stored", ram_m[4], 8'h94);
        chk("R10 cut byte ignored", ram_m[7], 8'h00);

        // R6/R5 RAM burst read and wrap
        do_read(mk_cmd(1, 5'd31, 1), NRAM + 1);
        for (int i = 0; i < NRAM; i++) chk("R6 ram burst read", rbuf[i], exp_ram[i]);
        chk("R5 burst wraps to 0", rbuf[NRAM], exp_ram[0]);

        // R12 snapshot during clock burst read
        start(); send_byte(mk_cmd(0, 5'd31, 1)); oe_any = 1'b0; oe_all = 1'b1;
        recv_byte(rbuf[0]); recv_byte(rbuf[1]);
        poke_idx = 5; poke_val = 8'h99; poke_go = 1'b1;
        @(negedge clk); poke_go = 1'b0;
        for (int k = 2; k < 8; k++) recv_byte(rbuf[k]);
        stop();
        chk("R12 snapshot kept", rbuf[5], exp_tk[5]);
        exp_tk[5] = 8'h99;
        do_read(mk_cmd(0, 5'd5, 1), 1);
        chk("R12 next read fresh", rbuf[0], 8'h99);

        // R1 abort mid-read and mid-write
        start(); send_byte(mk_cmd(1, 5'd5, 1));
        sclk = 1'b0; hold();
        chk("R3 drive after first fall", oe, 1'b1);
        en = 1'b0; hold(); hold();
        chk("R1 abort releases line", oe, 1'b0);
        c0 = ram_we_cnt;
        start(); send_byte(mk_cmd(1, 5'd9, 0));
        for (int i = 0; i < 4; i++) begin sclk = 1'b0; din = 1'b1; hold(); sclk = 1'b1; hold(); end
        stop();
        chk("R1 abort write no strobe", ram_we_cnt - c0, 0);

        // R3 random single-byte traffic
        for (int k = 0; k < 30; k++) begin
            a = 5'($urandom_range(0, NRAM - 1));
            v = 8'($urandom);
            do_write(mk_cmd(1, a, 0), v); exp_ram[a] = v;
            do_read(mk_cmd(1, a, 1), 1);
            chk("R3 random read back", rbuf[0], exp_read(1, a));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule